// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block executes one integer operation across every lane of two 128-bit operand vectors in a single step. The caller picks the lane width per operation (8, 16, 32 or 64 bits) and whether lanes are read as signed or unsigned. The result goes to its own output register, so both source vectors stay intact. The operation set is:

- wrapping and clamping add and subtract
- absolute difference, maximum and minimum
- halving subtract
- bitwise AND, OR and NOT
- five lane compares that return all-ones or all-zeros masks
- widening add and subtract in two shapes

The block sits in the execute stage of a vector pipeline. It takes one operation per cycle, with `in_valid` marking an active cycle. It returns the result one clock later together with `out_valid`. No carry, borrow or clamp ever crosses a lane boundary.

Lane-size code on `lane_sz`: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = 64-bit lanes. For the widening shapes this code names the narrow source lane width N, and the result lanes are 2N bits. When `is_signed` is 1, lanes are two's complement; when it is 0, lanes are unsigned.

Top module: `simd_alu`

## Requirements
- R1: A cycle with `in_valid`=1 produces `out_valid`=1 with its result on `out_data` exactly one clock later. Operations may be issued on consecutive cycles. Reset (`rst_n`=0) clears `out_valid` and `out_data` to 0.
- R2: Opcode 0 adds and opcode 1 subtracts lane by lane, modulo 2^W for lane width W. A carry or borrow never reaches the neighbouring lane.
- R3: Opcode 2 (add) and opcode 3 (subtract) clamp each lane to its representable range instead of wrapping. The range is [-(2^(W-1)), 2^(W-1)-1] when signed and [0, 2^W-1] when unsigned.
- R4: Opcode 4 gives |a-b| per lane, using the signed or unsigned ordering, as a W-bit unsigned magnitude.
- R5: Opcode 5 gives the per-lane maximum and opcode 6 the per-lane minimum, under the selected ordering.
- R6: Opcode 7 gives the per-lane halving difference. This is bits W..1 of the exact (W+1)-bit difference a-b, that is floor((a-b)/2) taken modulo 2^W.
- R7: Opcode 8 gives `src_a & src_b`, opcode 9 gives `src_a | src_b` and opcode 10 gives `~src_a`. All three ignore the lane width.
- R8: Opcodes 11 (equal), 12 (a<=b), 13 (a<b), 14 (a>=b) and 15 (a>b) set every bit of a lane where the condition holds and clear every bit of a lane where it fails.
- R9: Long shape: opcode 16 adds and opcode 17 subtracts. Both take N-bit lanes from bits 63:0 of both operands, extend them to 2N bits, and give a full 128-bit result with 2N-bit lanes.
- R10: Wide shape: opcode 18 adds and opcode 19 subtracts. Both combine 2N-bit lanes of all of `src_a` with N-bit lanes of `src_b[63:0]`, each extended to 2N bits, and give 2N-bit result lanes.
- R11: Opcodes 20 to 31, and any widening opcode with `lane_sz`=3, produce an all-zero result that is still flagged valid.
- R12: During cycles with `in_valid`=0, `out_valid` is 0 and `out_data` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 5 | Operation select (codes in R2 to R11) |
| lane_sz | input | 2 | Lane width code: 0=8, 1=16, 2=32, 3=64 bits |
| is_signed | input | 1 | 1 = two's-complement lanes, 0 = unsigned |
| src_a | input | 128 | First operand vector |
| src_b | input | 128 | Second operand vector |
| out_valid | output | 1 | Result valid strobe, one cycle after `in_valid` |
| out_data | output | 128 | Registered result vector |

## Verification
The bench drives lanes at their extremes, such as 0x7F, 0x80, 0xFF and 0x00 replicated, so that clamping, compares and halving all hit the ends of their range under both signedness settings and all four lane widths. A design that used the unsigned limits for signed lanes would return 0xFF instead of 0x7F. A design that leaked a carry between lanes would corrupt the lane next to an overflowing one. A halving subtract built on only W bits would lose the sign of a large difference. The widening shapes are checked with both long and wide source layouts, where taking the narrow lanes from the wrong half or extending with the wrong sign shows up as wrong upper halves. The bench also runs the 64-bit illegal widening case, the unused opcodes, and idle cycles that must leave the result register untouched.

// File: rtl/simd_pkg.sv
// Shared constants for the packed SIMD integer ALU.
// Assumes a 5-bit opcode and a 2-bit lane-size code.
package simd_pkg;
    localparam int VEC_W  = 128;
    localparam int HALF_W = VEC_W / 2;
    localparam int NSZ    = 4;

    typedef logic [4:0] op_t;

    localparam op_t OP_ADD  = 5'd0;
    localparam op_t OP_SUB  = 5'd1;
    localparam op_t OP_QADD = 5'd2;
    localparam op_t OP_QSUB = 5'd3;
    localparam op_t OP_ABD  = 5'd4;
    localparam op_t OP_MAX  = 5'd5;
    localparam op_t OP_MIN  = 5'd6;
    localparam op_t OP_HSUB = 5'd7;
    localparam op_t OP_AND  = 5'd8;
    localparam op_t OP_OR   = 5'd9;
    localparam op_t OP_NOT  = 5'd10;
    localparam op_t OP_CEQ  = 5'd11;
    localparam op_t OP_CLE  = 5'd12;
    localparam op_t OP_CLT  = 5'd13;
    localparam op_t OP_CGE  = 5'd14;
    localparam op_t OP_CGT  = 5'd15;
    localparam op_t OP_ADDL = 5'd16;
    localparam op_t OP_SUBL = 5'd17;
    localparam op_t OP_ADDW = 5'd18;
    localparam op_t OP_SUBW = 5'd19;
endpackage

// File: rtl/simd_lane_unit.sv
// One lane of width W: arithmetic, clamping, ordering and compare ops.
// Works on a (W+1)-bit extension of both operands, so the difference
// and the sum are exact. Widening opcodes are treated as plain add or
// subtract, because the caller has already extended the operands.
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  op_t          op,
    input  logic         sgn,
    output logic [W-1:0] r
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0]   ax, bx, sum, dif;
    logic [W-1:0] sat_sum, sat_dif;
    logic         lt, eq;

    // Exact sum and difference, their clamped forms, and the lane result.
    always_comb begin
        ax  = {sgn & a[W-1], a};
        bx  = {sgn & b[W-1], b};
        sum = ax + bx;
        dif = ax - bx;
        lt  = dif[W];
        eq  = (a == b);

        sat_sum = sum[W-1:0];
        sat_dif = dif[W-1:0];
        if (sgn) begin
            if (sum[W] != sum[W-1]) sat_sum = sum[W] ? SMIN : SMAX;
            if (dif[W] != dif[W-1]) sat_dif = dif[W] ? SMIN : SMAX;
        end else begin
            if (sum[W]) sat_sum = '1;
            if (dif[W]) sat_dif = '0;
        end

        case (op)
            OP_ADD, OP_ADDL, OP_ADDW: r = sum[W-1:0];
            OP_SUB, OP_SUBL, OP_SUBW: r = dif[W-1:0];
            OP_QADD: r = sat_sum;
            OP_QSUB: r = sat_dif;
            OP_ABD:  r = lt ? (b - a) : (a - b);
            OP_MAX:  r = lt ? b : a;
            OP_MIN:  r = lt ? a : b;
            OP_HSUB: r = dif[W:1];
            OP_CEQ:  r = {W{eq}};
            OP_CLE:  r = {W{lt | eq}};
            OP_CLT:  r = {W{lt}};
            OP_CGE:  r = {W{~lt}};
            OP_CGT:  r = {W{~lt & ~eq}};
            default: r = '0;
        endcase
    end
endmodule

// File: rtl/simd_lane_group.sv
// All lanes of one fixed width across the full vector.
// Assumes VEC_W is a multiple of LANE_W.
module simd_lane_group
    import simd_pkg::*;
#(
    parameter int GVEC_W = 128,
    parameter int LANE_W = 8
) (
    input  logic [GVEC_W-1:0] a,
    input  logic [GVEC_W-1:0] b,
    input  op_t               op,
    input  logic              sgn,
    output logic [GVEC_W-1:0] r
);
    localparam int LANES = GVEC_W / LANE_W;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        simd_lane_unit #(.W(LANE_W)) u_lane (
            .a   (a[i*LANE_W +: LANE_W]),
            .b   (b[i*LANE_W +: LANE_W]),
            .op  (op),
            .sgn (sgn),
            .r   (r[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/simd_extend.sv
// Extends each SRC_W-bit lane of a narrow vector to 2*SRC_W bits, with
// sign or zero fill. Assumes IN_W is a multiple of SRC_W and
// OUT_W = 2*IN_W.
module simd_extend #(
    parameter int SRC_W = 8,
    parameter int IN_W  = 64,
    parameter int OUT_W = 2 * IN_W
) (
    input  logic [IN_W-1:0]  din,
    input  logic             sgn,
    output logic [OUT_W-1:0] dout
);
    localparam int LANES = IN_W / SRC_W;

    for (genvar k = 0; k < LANES; k++) begin : g_ext
        assign dout[k*2*SRC_W +: 2*SRC_W] =
            {{SRC_W{sgn & din[k*SRC_W + SRC_W - 1]}}, din[k*SRC_W +: SRC_W]};
    end
endmodule

// File: rtl/simd_alu.sv
// Packed SIMD integer ALU with a one-cycle registered result.
// There is one lane group per lane width, and lane_sz selects among them.
// For widening ops, the groups above 8 bits take operands extended from
// the next narrower width. Reset is synchronous and active low.
module simd_alu
    import simd_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [4:0]   op_code,
    input  logic [1:0]   lane_sz,
    input  logic         is_signed,
    input  logic [127:0] src_a,
    input  logic [127:0] src_b,
    output logic         out_valid,
    output logic [127:0] out_data
);
    logic [VEC_W-1:0] grp_a [NSZ];
    logic [VEC_W-1:0] grp_b [NSZ];
    logic [VEC_W-1:0] grp_r [NSZ];
    logic [VEC_W-1:0] nxt;
    logic             is_widen, is_long;

    assign is_widen = (op_code >= OP_ADDL) && (op_code <= OP_SUBW);
    assign is_long  = (op_code == OP_ADDL) || (op_code == OP_SUBL);

    for (genvar g = 0; g < NSZ; g++) begin : g_size
        localparam int LW = 8 << g;
        if (g == 0) begin : g_base
            assign grp_a[g] = src_a;
            assign grp_b[g] = src_b;
        end else begin : g_wide
            logic [VEC_W-1:0] ext_a, ext_b;
            simd_extend #(.SRC_W(LW/2), .IN_W(HALF_W)) u_ext_a (
                .din (src_a[HALF_W-1:0]), .sgn (is_signed), .dout (ext_a));
            simd_extend #(.SRC_W(LW/2), .IN_W(HALF_W)) u_ext_b (
                .din (src_b[HALF_W-1:0]), .sgn (is_signed), .dout (ext_b));
            assign grp_a[g] = (is_widen && is_long) ? ext_a : src_a;
            assign grp_b[g] = is_widen ? ext_b : src_b;
        end
        simd_lane_group #(.GVEC_W(VEC_W), .LANE_W(LW)) u_grp (
            .a   (grp_a[g]),
            .b   (grp_b[g]),
            .op  (op_code),
            .sgn (is_signed),
            .r   (grp_r[g])
        );
    end

    // Choose the bitwise result, the lane-group result, or zero.
    always_comb begin
        nxt = '0;
        if (op_code == OP_AND)      nxt = src_a & src_b;
        else if (op_code == OP_OR)  nxt = src_a | src_b;
        else if (op_code == OP_NOT) nxt = ~src_a;
        else if (is_widen) begin
            case (lane_sz)
                2'd0:    nxt = grp_r[1];
                2'd1:    nxt = grp_r[2];
                2'd2:    nxt = grp_r[3];
                default: nxt = '0;
            endcase
        end else if (op_code < OP_ADDL) begin
            case (lane_sz)
                2'd0:    nxt = grp_r[0];
                2'd1:    nxt = grp_r[1];
                2'd2:    nxt = grp_r[2];
                default: nxt = grp_r[3];
            endcase
        end
    end

    // Result register and valid strobe; the result holds while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= nxt;
        end
    end
endmodule

// File: rtl/simd_alu_chk.sv
// Property checker for simd_alu, attached with bind below.
// It arms one cycle after reset is released, so that every $past
// sample it uses comes from a cycle out of reset.
module simd_alu_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [4:0]   op_code,
    input logic [1:0]   lane_sz,
    input logic [127:0] src_a,
    input logic         out_valid,
    input logic [127:0] out_data
);
    logic armed;

    // Arm the checks once a full cycle out of reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    function automatic logic bytes_solid(input logic [127:0] v);
        for (int i = 0; i < 16; i++)
            if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) return 1'b0;
        return 1'b1;
    endfunction

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (out_valid == $past(in_valid)));

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !$past(in_valid)) |-> $stable(out_data));

    p_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(op_code) >= 5'd11 && $past(op_code) <= 5'd15)
        |-> bytes_solid(out_data));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(op_code) > 5'd19) |-> (out_data == '0));

    p_wide64_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(op_code) >= 5'd16 && $past(op_code) <= 5'd19
         && $past(lane_sz) == 2'd3) |-> (out_data == '0));

    p_not_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(in_valid) && $past(op_code) == 5'd10) |-> (out_data == ~$past(src_a)));
endmodule

bind simd_alu simd_alu_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .lane_sz   (lane_sz),
    .src_a     (src_a),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/sim_simd_alu.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected results computed by a
// behavioural lane model, and the monitor compares them at falling edges.
module sim_simd_alu;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [4:0]   op_code = '0;
    logic [1:0]   lane_sz = '0;
    logic         is_signed = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         out_valid;
    logic [127:0] out_data;

    int checks = 0;
    int failures = 0;
    int sent = 0;
    int got = 0;
    logic [127:0] exp_q [$];
    string        tag_q [$];
    logic [127:0] last_exp = '0;

    always #5 clk = ~clk;

    simd_alu u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .lane_sz(lane_sz), .is_signed(is_signed), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic signed [67:0] lget(input logic [127:0] v, input int w,
                                                input int i, input bit sg);
        logic [63:0] raw;
        logic signed [67:0] val;
        raw = 64'(v >> (i*w));
        if (w < 64) raw = raw & ((64'd1 << w) - 64'd1);
        val = $signed({4'b0, raw});
        if (sg && raw[w-1]) val = val - (68'sd1 <<< w);
        return val;
    endfunction

    function automatic logic [127:0] lput(input logic [127:0] v, input int w,
                                          input int i, input logic signed [67:0] x);
        logic [127:0] m;
        m = (128'd1 << w) - 128'd1;
        return v | ((128'(x) & m) << (i*w));
    endfunction

    function automatic logic [127:0] model(input logic [4:0] op, input logic [1:0] sz,
                                           input bit sg, input logic [127:0] a,
                                           input logic [127:0] b);
        int w;
        logic [127:0] r;
        logic signed [67:0] av, bv, x, hi, lo;
        w = 8 << sz;
        r = '0;
        if (op == 5'd8)  return a & b;
        if (op == 5'd9)  return a | b;
        if (op == 5'd10) return ~a;
        if (op > 5'd19)  return '0;
        if (op >= 5'd16) begin
            if (sz == 2'd3) return '0;
            for (int i = 0; i < 64 / w; i++) begin
                av = (op == 5'd16 || op == 5'd17) ? lget(a, w, i, sg) : lget(a, 2*w, i, sg);
                bv = lget(b, w, i, sg);
                x  = (op == 5'd16 || op == 5'd18) ? av + bv : av - bv;
                r  = lput(r, 2*w, i, x);
            end
            return r;
        end
        hi = sg ? (68'sd1 <<< (w-1)) - 68'sd1 : (68'sd1 <<< w) - 68'sd1;
        lo = sg ? -(68'sd1 <<< (w-1)) : 68'sd0;
        for (int i = 0; i < 128 / w; i++) begin
            av = lget(a, w, i, sg);
            bv = lget(b, w, i, sg);
            case (op)
                5'd0: x = av + bv;
                5'd1: x = av - bv;
                5'd2: begin x = av + bv; if (x > hi) x = hi; if (x < lo) x = lo; end
                5'd3: begin x = av - bv; if (x > hi) x = hi; if (x < lo) x = lo; end
                5'd4: x = (av > bv) ? av - bv : bv - av;
                5'd5: x = (av > bv) ? av : bv;
                5'd6: x = (av < bv) ? av : bv;
                5'd7: x = (av - bv) >>> 1;
                5'd11: x = (av == bv) ? -68'sd1 : 68'sd0;
                5'd12: x = (av <= bv) ? -68'sd1 : 68'sd0;
                5'd13: x = (av <  bv) ? -68'sd1 : 68'sd0;
                5'd14: x = (av >= bv) ? -68'sd1 : 68'sd0;
                default: x = (av > bv) ? -68'sd1 : 68'sd0;
            endcase
            r = lput(r, w, i, x);
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [4:0] op, input logic [1:0] sz);
        if (op >= 5'd16 && op <= 5'd19 && sz == 2'd3) return "R11";
        case (op)
            5'd0, 5'd1: return "R2";
            5'd2, 5'd3: return "R3";
            5'd4: return "R4";
            5'd5, 5'd6: return "R5";
            5'd7: return "R6";
            5'd8, 5'd9, 5'd10: return "R7";
            5'd11, 5'd12, 5'd13, 5'd14, 5'd15: return "R8";
            5'd16, 5'd17: return "R9";
            5'd18, 5'd19: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Driver: present one operation and queue its expected result.
    task automatic send(input logic [4:0] op, input logic [1:0] sz, input bit sg,
                        input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        in_valid  = 1'b1;
        op_code   = op;
        lane_sz   = sz;
        is_signed = sg;
        src_a     = a;
        src_b     = b;
        last_exp  = model(op, sz, sg, a, b);
        exp_q.push_back(last_exp);
        tag_q.push_back(tag_of(op, sz));
        sent++;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [127:0] pick_vec();
        logic [7:0] pat [4];
        pat[0] = 8'h7F; pat[1] = 8'h80; pat[2] = 8'hFF; pat[3] = 8'h00;
        case ($urandom_range(0, 3))
            0: return {16{pat[$urandom_range(0, 3)]}};
            1: return {8{pat[$urandom_range(0, 3)], 8'($urandom)}};
            default: return {$urandom, $urandom, $urandom, $urandom};
        endcase
    endfunction

    // Monitor: every valid result must match the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            got++;
            if (exp_q.size() == 0) begin
                checks++;
                failures++;
                $display("FAIL R1 actual=unexpected valid expected=no result pending");
            end else begin
                check(tag_q.pop_front(), out_data, exp_q.pop_front());
            end
        end
    end

    // Watchdog: an expired run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {127'b0, out_valid}, 128'd0);
        check("R1", out_data, 128'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: a carry out of byte 0 must not reach byte 1
        send(5'd0, 2'd0, 1'b0, 128'h00FF, 128'h0001);
        send(5'd1, 2'd1, 1'b0, 128'h0000_0000, 128'h0000_0001);
        // R3: clamping at both ends, signed and unsigned, all widths
        send(5'd2, 2'd0, 1'b0, {16{8'hF0}}, {16{8'h20}});
        send(5'd2, 2'd0, 1'b1, {16{8'h70}}, {16{8'h20}});
        send(5'd3, 2'd0, 1'b1, {16{8'h80}}, {16{8'h01}});
        send(5'd3, 2'd3, 1'b0, {2{64'h5}}, {2{64'h9}});
        send(5'd2, 2'd3, 1'b1, {2{64'h7FFF_FFFF_FFFF_FFFF}}, {2{64'h1}});
        // R4 / R5: extremes under both orderings
        send(5'd4, 2'd0, 1'b1, {16{8'h7F}}, {16{8'h80}});
        send(5'd5, 2'd1, 1'b1, {8{16'h8000}}, {8{16'h0001}});
        send(5'd6, 2'd1, 1'b0, {8{16'h8000}}, {8{16'h0001}});
        // R6: halving with a difference that needs the extra bit
        send(5'd7, 2'd0, 1'b1, {16{8'h7F}}, {16{8'h80}});
        send(5'd7, 2'd2, 1'b0, {4{32'h0}}, {4{32'hFFFF_FFFF}});
        // R7: bitwise forms
        send(5'd8, 2'd2, 1'b0, {4{32'hF0F0_1234}}, {4{32'h0FF0_FFFF}});
        send(5'd10, 2'd3, 1'b1, {4{32'h1234_5678}}, '0);
        // R8: compares at the sign boundary
        send(5'd13, 2'd0, 1'b1, {16{8'h80}}, {16{8'h7F}});
        send(5'd13, 2'd0, 1'b0, {16{8'h80}}, {16{8'h7F}});
        send(5'd11, 2'd3, 1'b0, {64'h5, 64'h6}, {64'h5, 64'h5});
        // R9 / R10: widening shapes with negative narrow lanes
        send(5'd16, 2'd0, 1'b1, {64'h0, {8{8'hFF}}}, {64'h0, {8{8'hFF}}});
        send(5'd17, 2'd2, 1'b0, {64'h0, 64'h0000_0001_FFFF_FFFF}, {64'h0, 64'h0000_0002_0000_0001});
        send(5'd18, 2'd1, 1'b1, {4{32'h0000_7FFF}}, {64'h0, {4{16'h8000}}});
        send(5'd19, 2'd0, 1'b0, {8{16'h0100}}, {64'h0, {8{8'hFF}}});
        // R11: illegal widening and unused opcodes
        send(5'd16, 2'd3, 1'b0, {4{32'hDEAD_BEEF}}, {4{32'h1}});
        send(5'd25, 2'd0, 1'b0, {4{32'hDEAD_BEEF}}, {4{32'h1}});
        send(5'd9, 2'd1, 1'b0, 128'h1234, 128'h8000_0000);

        // R12: result holds and valid drops while idle
        idle(4);
        check("R12", out_data, last_exp);
        check("R12", {127'b0, out_valid}, 128'd0);

        // Back-to-back random stream over all opcodes, widths and signedness
        for (int n = 0; n < 2000; n++)
            send(5'($urandom_range(0, 23)), 2'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), pick_vec(), pick_vec());
        idle(3);
        check("R12", out_data, last_exp);
        // R1: one result per issued operation
        check("R1", 128'(got), 128'(sent));
        check("R1", 128'(exp_q.size()), 128'd0);
        finish_run();
    end
endmodule